// File: doc/BRIEF.md
# Triple-Run Time-Redundancy Voting Controller

This controller makes a streaming compute unit more reliable by running every job more than once on the same hardware. It starts the unit, collects one result word per cycle into a first buffer, then runs the same job again into a second buffer while comparing each new word against the first result. Both of these runs always finish in full. If every address agreed, the stored result goes to the output memory. If any address disagreed, the job is run again, and each disagreeing address takes the first later value that matches either stored copy. That value is the two-of-three majority.

Before each run the controller strobes a reconfiguration request, so the compute unit starts from a freshly loaded state and carries nothing over from the previous run. A parameter sets the most runs a job may use. An address that still has no agreeing pair when that limit is reached is committed with its first-run value and raises a sticky uncorrectable flag. The controller also checks every word it receives against its own word index and the run length, and reports a sticky protocol error when either one is wrong.

Top module: `tr_vote_ctrl`

## Requirements
- R1: While reset is active and right after it, job_done, cfg_reload_req, cu_start, om_we, mismatch_seen, uncorrectable and proto_err are all 0.
- R2: The controller raises cfg_reload_req for one cycle before each run and raises cu_start in the next cycle, so a job shows equal numbers of reload strobes and start pulses.
- R3: The first run fills buffer one and the second run fills buffer two, and the second run always completes. When no address differs, the job uses exactly two runs. The output memory is then written with the first-run words at addresses 0 to N_WORDS-1, in ascending order, one per cycle.
- R4: If any address differs after the second run, a third run follows. Each address receives the majority of its values, so an error confined to one run (persistent from any address onward) is fully corrected.
- R5: mismatch_seen is 1 after a job whose first two runs differed at one or more addresses. It is cleared when the next job is accepted.
- R6: An address with no agreeing pair after MAX_RUNS runs is committed with its first-run value, and uncorrectable is set and stays set until reset.
- R7: A job never uses more than MAX_RUNS runs. A run after the third happens only while some address is still unresolved.
- R8: job_done is a single-cycle pulse in the cycle right after the last output-memory write.
- R9: proto_err is set, and stays set until reset, when a received word's cu_addr differs from its index within the run, or when the word marked by cu_last is not word number N_WORDS-1. Words past N_WORDS are discarded.
- R10: job_start has no effect while a job is in progress. Such a pulse starts no extra run and no extra job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| job_start | input | 1 | Start a job; taken only when idle |
| job_done | output | 1 | One-cycle pulse after the final output write |
| cfg_reload_req | output | 1 | Request a configuration reload before a run |
| cu_start | output | 1 | Start pulse to the compute unit |
| cu_valid | input | 1 | Result word present |
| cu_last | input | 1 | Marks the final word of a run |
| cu_addr | input | ADDR_W | Index the compute unit gives the word |
| cu_data | input | DATA_W | Result word |
| om_we | output | 1 | Output memory write enable |
| om_addr | output | ADDR_W | Output memory write address |
| om_wdata | output | DATA_W | Output memory write data |
| mismatch_seen | output | 1 | The current or last job saw a difference between its first two runs |
| uncorrectable | output | 1 | Sticky: some address could not be voted |
| proto_err | output | 1 | Sticky: address or run-length violation |

## Verification
The checker tests these properties on every cycle:
- each start pulse directly follows a reload strobe;
- a job uses between two and MAX_RUNS runs;
- the commit writes ascend from address zero and end one cycle before the done pulse;
- the two error flags never drop.

Other behaviours need the bench's scenarios, because only a known stream of run values defines the right result:
- whether each address receives the correct voted word;
- whether the mismatch flag matches the data;
- whether a third run happens only when required;
- whether protocol faults are detected.

// File: rtl/tr_vote_pkg.sv
package tr_vote_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RELOAD  = 3'd1,
    ST_START   = 3'd2,
    ST_COLLECT = 3'd3,
    ST_COMMIT  = 3'd4,
    ST_DONE    = 3'd5
  } ctrl_state_e;
endpackage

// File: rtl/tr_rst_sync.sv
module tr_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tr_result_buf.sv
module tr_result_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // storage array: no reset, written only under its enable
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/tr_word_vote.sv
module tr_word_vote #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] new_word,
  input  logic [DATA_W-1:0] prim_word,
  input  logic [DATA_W-1:0] cmp_word,
  output logic              agree_prim,
  output logic              agree_any
);
  always_comb begin
    agree_prim = (new_word == prim_word);
    agree_any  = agree_prim | (new_word == cmp_word);
  end
endmodule

// File: rtl/tr_seq_ctrl.sv
module tr_seq_ctrl
  import tr_vote_pkg::*;
#(
  parameter int N_WORDS  = 16,
  parameter int MAX_RUNS = 3,
  parameter int CNT_W    = 5,
  parameter int RUN_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             job_start,
  input  logic             word_take,
  input  logic             run_end,
  input  logic             still_open,
  output ctrl_state_e      state,
  output logic [RUN_W-1:0] run_idx,
  output logic [CNT_W-1:0] word_cnt
);
  ctrl_state_e      state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ctrl_en;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (job_start) begin
          state_d = ST_RELOAD;
          run_d   = RUN_W'(1);
        end
      end
      ST_RELOAD: state_d = ST_START;
      ST_START: begin
        state_d = ST_COLLECT;
        cnt_d   = '0;
      end
      ST_COLLECT: begin
        if (word_take) cnt_d = cnt_q + CNT_W'(1);
        if (run_end) begin
          if ((run_q == RUN_W'(1)) || (still_open && (run_q < RUN_W'(MAX_RUNS)))) begin
            state_d = ST_RELOAD;
            run_d   = run_q + RUN_W'(1);
          end else begin
            state_d = ST_COMMIT;
            cnt_d   = '0;
          end
        end
      end
      ST_COMMIT: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(N_WORDS - 1)) state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctrl_en = (state_q != ST_IDLE) | job_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= '0;
      cnt_q   <= '0;
    end else if (ctrl_en) begin
      state_q <= state_d;
      run_q   <= run_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state    = state_q;
  assign run_idx  = run_q;
  assign word_cnt = cnt_q;
endmodule

// File: rtl/tr_vote_ctrl.sv
module tr_vote_ctrl
  import tr_vote_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int N_WORDS  = 16,
  parameter int MAX_RUNS = 3,
  parameter int ADDR_W   = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              job_start,
  output logic              job_done,
  output logic              cfg_reload_req,
  output logic              cu_start,
  input  logic              cu_valid,
  input  logic              cu_last,
  input  logic [ADDR_W-1:0] cu_addr,
  input  logic [DATA_W-1:0] cu_data,
  output logic              om_we,
  output logic [ADDR_W-1:0] om_addr,
  output logic [DATA_W-1:0] om_wdata,
  output logic              mismatch_seen,
  output logic              uncorrectable,
  output logic              proto_err
);
  localparam int CNT_W = $clog2(N_WORDS + 1);
  localparam int RUN_W = $clog2(MAX_RUNS + 1);
  localparam int N_BUF = 2;

  logic              rst_sync_n;
  ctrl_state_e       state;
  logic [RUN_W-1:0]  run_idx;
  logic [CNT_W-1:0]  word_cnt;
  logic [ADDR_W-1:0] idx;
  logic              in_collect, room, word_take, run_end;
  logic              is_run1, is_run2, is_vote, settle;
  logic              agree_prim, agree_any, still_open;
  logic [N_WORDS-1:0] resolved_q, resolved_d;
  logic              rsv_en;
  logic              mis_q, unc_q, prot_q;
  logic              bad_word;
  logic [N_BUF-1:0]  buf_we;
  logic [DATA_W-1:0] buf_rd [N_BUF];

  tr_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  tr_seq_ctrl #(
    .N_WORDS  (N_WORDS),
    .MAX_RUNS (MAX_RUNS),
    .CNT_W    (CNT_W),
    .RUN_W    (RUN_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .job_start  (job_start),
    .word_take  (word_take),
    .run_end    (run_end),
    .still_open (still_open),
    .state      (state),
    .run_idx    (run_idx),
    .word_cnt   (word_cnt)
  );

  assign idx        = word_cnt[ADDR_W-1:0];
  assign in_collect = (state == ST_COLLECT);
  assign room       = (word_cnt < CNT_W'(N_WORDS));
  assign word_take  = in_collect & cu_valid & room;
  assign run_end    = in_collect & cu_valid & cu_last;
  assign is_run1    = (run_idx == RUN_W'(1));
  assign is_run2    = (run_idx == RUN_W'(2));
  assign is_vote    = (run_idx >= RUN_W'(3));

  // buffer 0 holds the primary run, buffer 1 the comparing run / voted words
  for (genvar g = 0; g < N_BUF; g++) begin : g_buf
    tr_result_buf #(
      .DATA_W (DATA_W),
      .DEPTH  (N_WORDS),
      .ADDR_W (ADDR_W)
    ) u_buf (
      .clk     (clk),
      .wr_en   (buf_we[g]),
      .wr_addr (idx),
      .wr_data (cu_data),
      .rd_addr (idx),
      .rd_data (buf_rd[g])
    );
  end

  tr_word_vote #(.DATA_W(DATA_W)) u_vote (
    .new_word   (cu_data),
    .prim_word  (buf_rd[0]),
    .cmp_word   (buf_rd[1]),
    .agree_prim (agree_prim),
    .agree_any  (agree_any)
  );

  assign settle    = word_take & is_vote & ~resolved_q[idx] & agree_any;
  assign buf_we[0] = word_take & is_run1;
  assign buf_we[1] = (word_take & is_run2) | settle;

  always_comb begin
    resolved_d = resolved_q;
    if ((state == ST_START) && is_run1) resolved_d = '0;
    if (word_take && is_run2)           resolved_d[idx] = agree_prim;
    if (settle)                         resolved_d[idx] = 1'b1;
  end

  assign rsv_en     = word_take | (state == ST_START);
  assign still_open = ~&resolved_d;
  assign bad_word   = in_collect & cu_valid &
                      (~room | (cu_addr != idx) |
                       (cu_last & (word_cnt != CNT_W'(N_WORDS - 1))));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      resolved_q <= '0;
    end else if (rsv_en) begin
      resolved_q <= resolved_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mis_q  <= 1'b0;
      unc_q  <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      if ((state == ST_IDLE) && job_start)      mis_q <= 1'b0;
      else if (run_end && is_run2 && still_open) mis_q <= 1'b1;
      if (run_end && !is_run1 && still_open && (run_idx == RUN_W'(MAX_RUNS)))
        unc_q <= 1'b1;
      if (bad_word) prot_q <= 1'b1;
    end
  end

  assign cfg_reload_req = (state == ST_RELOAD);
  assign cu_start       = (state == ST_START);
  assign om_we          = (state == ST_COMMIT);
  assign om_addr        = idx;
  assign om_wdata       = resolved_q[idx] ? buf_rd[1] : buf_rd[0];
  assign job_done       = (state == ST_DONE);
  assign mismatch_seen  = mis_q;
  assign uncorrectable  = unc_q;
  assign proto_err      = prot_q;
endmodule

// File: rtl/tr_vote_ctrl_chk.sv
module tr_vote_ctrl_chk #(
  parameter int N_WORDS  = 16,
  parameter int MAX_RUNS = 3,
  parameter int AW       = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          job_done,
  input logic          cfg_reload_req,
  input logic          cu_start,
  input logic          om_we,
  input logic [AW-1:0] om_addr,
  input logic          uncorrectable,
  input logic          proto_err
);
  logic [3:0] starts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        starts_q <= '0;
    else if (job_done) starts_q <= '0;
    else if (cu_start) starts_q <= starts_q + 4'd1;
  end

  AST_START_AFTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cu_start |-> $past(cfg_reload_req)); // R2
  AST_RELOAD_THEN_START: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_reload_req |=> cu_start); // R2
  AST_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cu_start |-> (starts_q < 4'(MAX_RUNS))); // R7
  AST_MIN_TWO_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> (starts_q >= 4'd2)); // R3
  AST_FIRST_WRITE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(om_we) |-> (om_addr == '0)); // R3
  AST_WRITE_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (om_we && $past(om_we)) |-> (om_addr == $past(om_addr) + AW'(1))); // R3
  AST_DONE_AFTER_LAST_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |-> ($past(om_we) && ($past(om_addr) == AW'(N_WORDS - 1)))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    job_done |=> !job_done); // R8
  AST_UNCORR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    uncorrectable |=> uncorrectable); // R6
  AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err); // R9
endmodule

bind tr_vote_ctrl tr_vote_ctrl_chk #(
  .N_WORDS  (N_WORDS),
  .MAX_RUNS (MAX_RUNS),
  .AW       (ADDR_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .job_done       (job_done),
  .cfg_reload_req (cfg_reload_req),
  .cu_start       (cu_start),
  .om_we          (om_we),
  .om_addr        (om_addr),
  .uncorrectable  (uncorrectable),
  .proto_err      (proto_err)
);

// File: tb/tr_vote_ctrl_bench.sv
module tr_vote_ctrl_bench;
  localparam int DW   = 8;
  localparam int NW   = 16;
  localparam int MAXR = 3;
  localparam int AW   = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          job_start = 1'b0;
  logic          job_done, cfg_reload_req, cu_start;
  logic          cu_valid = 1'b0;
  logic          cu_last = 1'b0;
  logic [AW-1:0] cu_addr = '0;
  logic [DW-1:0] cu_data = '0;
  logic          om_we;
  logic [AW-1:0] om_addr;
  logic [DW-1:0] om_wdata;
  logic          mismatch_seen, uncorrectable, proto_err;

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] golden [NW];
  int            from_r [6];
  logic [DW-1:0] mask_r [6];
  bit            short_run = 0;
  bit            bad_addr_mode = 0;
  bit            unc_exp = 0;
  logic [DW-1:0] omem [NW];

  always #2 clk = ~clk;

  tr_vote_ctrl #(.DATA_W(DW), .N_WORDS(NW), .MAX_RUNS(MAXR)) u_tr_vote_ctrl (
    .clk(clk), .rst_n(rst_n), .job_start(job_start), .job_done(job_done),
    .cfg_reload_req(cfg_reload_req), .cu_start(cu_start),
    .cu_valid(cu_valid), .cu_last(cu_last), .cu_addr(cu_addr), .cu_data(cu_data),
    .om_we(om_we), .om_addr(om_addr), .om_wdata(om_wdata),
    .mismatch_seen(mismatch_seen), .uncorrectable(uncorrectable), .proto_err(proto_err)
  );

  function automatic logic [DW-1:0] run_word(int run, int i);
    int r = (run > 5) ? 5 : run;
    return golden[i] ^ ((i >= from_r[r]) ? mask_r[r] : '0);
  endfunction

  function automatic bit open_after(int last);
    for (int i = 0; i < NW; i++) begin
      bit ok = (run_word(1, i) == run_word(2, i));
      for (int k = 3; k <= last; k++)
        if (run_word(k, i) == run_word(1, i) || run_word(k, i) == run_word(2, i)) ok = 1;
      if (!ok) return 1;
    end
    return 0;
  endfunction

  function automatic int exp_runs();
    int runs = 2;
    while (runs < MAXR && open_after(runs)) runs++;
    return runs;
  endfunction

  function automatic logic [DW-1:0] exp_word(int i);
    logic [DW-1:0] v1 = run_word(1, i);
    logic [DW-1:0] v2 = run_word(2, i);
    if (v1 == v2) return v1;
    for (int r = 3; r <= MAXR; r++)
      if (run_word(r, i) == v1 || run_word(r, i) == v2) return run_word(r, i);
    return v1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int r = 0; r < 6; r++) begin
      from_r[r] = NW;
      mask_r[r] = '0;
    end
  endtask

  // compute unit model: replays the job with the configured per-run faults
  initial begin
    int cu_run = 0;
    forever begin
      @(negedge clk);
      if (job_done) cu_run = 0;
      if (cu_start) begin
        int n;
        cu_run++;
        n = (short_run && cu_run == 1) ? NW - 1 : NW;
        for (int i = 0; i < n; i++) begin
          @(negedge clk);
          cu_valid = 1'b1;
          cu_addr  = (bad_addr_mode && cu_run == 1 && i == 3) ? AW'(5) : AW'(i);
          cu_data  = run_word(cu_run, i);
          cu_last  = (i == n - 1);
        end
        @(negedge clk);
        cu_valid = 1'b0;
        cu_last  = 1'b0;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({job_done, cfg_reload_req, cu_start, om_we, mismatch_seen, uncorrectable, proto_err} == 7'b0,
        "R1 outputs in reset", 32'({job_done, cfg_reload_req, cu_start, om_we}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({job_done, cfg_reload_req, cu_start, om_we, mismatch_seen, uncorrectable, proto_err} == 7'b0,
        "R1 outputs after reset", 32'({mismatch_seen, uncorrectable, proto_err}), 0);
    unc_exp = 0;
  endtask

  task automatic run_job(input bit poke_busy, input bit check_data);
    int reloads = 0, starts = 0, writes = 0, order_err = 0;
    int cyc = 0, last_we = -10, done_cyc = -1;
    int er = exp_runs();
    bit em = open_after(2);
    bit data_ok = 1;
    int bad_i = 0;
    if (open_after(er)) unc_exp = 1;
    job_start = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      job_start = (poke_busy && cyc == 10);
      if (cfg_reload_req) reloads++;
      if (cu_start) starts++;
      if (om_we) begin
        if (int'(om_addr) != writes) order_err++;
        omem[om_addr] = om_wdata;
        writes++;
        last_we = cyc;
      end
      if (job_done) begin done_cyc = cyc; break; end
      if (cyc > 3000) break;
    end
    chk(done_cyc > 0, "R8 job completes", 32'(cyc), 0);
    chk(reloads == er, "R7 run count", 32'(reloads), 32'(er));
    chk(starts == reloads, "R2 start per reload", 32'(starts), 32'(reloads));
    chk(writes == NW && order_err == 0, "R3 commit order", 32'(writes), 32'(NW));
    chk(done_cyc == last_we + 1, "R8 done after last write", 32'(done_cyc), 32'(last_we + 1));
    if (check_data) begin
      for (int i = NW - 1; i >= 0; i--)
        if (omem[i] !== exp_word(i)) begin data_ok = 0; bad_i = i; end
      chk(data_ok, unc_exp ? "R6 committed words" : "R4 voted words",
          32'(omem[bad_i]), 32'(exp_word(bad_i)));
    end
    chk(mismatch_seen == em, "R5 mismatch flag", 32'(mismatch_seen), 32'(em));
    chk(uncorrectable == unc_exp, "R6 uncorrectable flag", 32'(uncorrectable), 32'(unc_exp));
    @(negedge clk);
    chk(!job_done, "R8 done is one pulse", 32'(job_done), 0);
    if (poke_busy) begin
      int extra = 0;
      repeat (4) begin
        @(negedge clk);
        if (cfg_reload_req || cu_start) extra++;
      end
      chk(extra == 0, "R10 busy start ignored", 32'(extra), 0);
    end
  endtask

  task automatic rand_golden();
    for (int i = 0; i < NW; i++) golden[i] = DW'($urandom);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    clear_faults();
    rand_golden();
    do_reset();

    // clean job with a start pulse while busy (R3, R10)
    run_job(1, 1);
    // persistent error in the primary run at the last address (R4, R5)
    rand_golden(); clear_faults();
    from_r[1] = NW - 1; mask_r[1] = 8'h40;
    run_job(0, 1);
    // persistent error in the comparing run from address 0 (R4)
    rand_golden(); clear_faults();
    from_r[2] = 0; mask_r[2] = 8'hFF;
    run_job(0, 1);
    // clean job clears the mismatch flag (R5)
    clear_faults();
    run_job(0, 1);

    // random single-run faults (R3, R4, R5)
    for (int j = 0; j < 24; j++) begin
      int sel;
      rand_golden(); clear_faults();
      sel = int'($urandom % 4);
      if (sel != 0) begin
        from_r[sel] = int'($urandom % NW);
        mask_r[sel] = DW'(($urandom % 255) + 1);
      end
      run_job(0, 1);
    end

    // no agreeing pair from address 5 onward (R6, R7)
    rand_golden(); clear_faults();
    from_r[1] = 5; mask_r[1] = 8'h01;
    from_r[3] = 5; mask_r[3] = 8'h02;
    run_job(0, 1);
    // flag stays set through a clean job (R6)
    clear_faults();
    run_job(0, 1);

    // wrong address tag on one word (R9)
    do_reset();
    rand_golden(); clear_faults();
    bad_addr_mode = 1;
    run_job(0, 1);
    bad_addr_mode = 0;
    chk(proto_err, "R9 address tag error", 32'(proto_err), 1);

    // short primary run (R9)
    do_reset();
    short_run = 1;
    run_job(0, 0);
    short_run = 0;
    chk(proto_err, "R9 run length error", 32'(proto_err), 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule